// File: doc/BRIEF.md
# Regularised 2x2 Velocity Solver

This block takes the three distinct entries of a symmetric 2x2 matrix (`a11`, `a12`, `a22`) and a two-element right-hand vector (`b1`, `b2`), all signed fixed-point integers. It returns the velocity pair (`vx`, `vy`) that solves the linear system. The block sits after the stage that accumulates the windowed gradient products, and before the stage that formats results. Each operand is converted to a 25-bit reduced-precision float. Six single-cycle multipliers form the cross products. Three single-cycle subtractors form the determinant and the two numerators. Each velocity component is then one division by the determinant.

Division is the slow operation. Each divider is a sequential restoring unit with a fixed 21-cycle latency. The dividers are grouped into `WAYS` ways, with two dividers per way (one per component). Ways are handed work in round-robin order. With three ways the block accepts a new solve every 7 cycles. Every divider has the same fixed latency, so results come out in the order the solves went in.

Top module: `vel_solver2x2`

## Requirements
- R1: Every result uses a 25-bit float. Bit 24 is the sign, bits 23:16 are the exponent with bias 127, and bits 15:0 are the fraction below an implicit leading one. Zero is encoded as all bits clear. For example, 2.0 is 25'h0800000, -3.0 is 25'h1808000 and 1.0 is 25'h07F0000.
- R2: Each signed fixed-point input is converted to the float format, keeping its 17 leading significant bits by truncation. A zero input converts to the all-zero encoding.
- R3: The block computes det = a11*a22 - a12*a12. It returns vx = (a22*b1 - a12*b2)/det and vy = (a11*b2 - a12*b1)/det, each accurate to within the truncation error of a 16-bit fraction carried through these operations.
- R4: When the determinant float is zero, both velocity outputs are the all-zero encoding and `out_invalid` is 1 in the result cycle. For any nonzero determinant, `out_invalid` is 0.
- R5: `out_valid` goes high for exactly one cycle, 4 + DIV_CYCLES (25) cycles after the clock edge that sampled `in_valid`.
- R6: A new solve may be presented every ceil(DIV_CYCLES/WAYS) cycles (7 by default). A stream at exactly that spacing loses no results.
- R7: Results leave in the order their inputs arrived. No result appears without a matching input.
- R8: During and after reset, `out_valid` is low. Whenever `out_valid` is low, `out_vx`, `out_vy` and `out_invalid` are zero.
- R9: A zero numerator with a nonzero determinant gives an exactly zero velocity component, with `out_invalid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a cycle carrying a new solve |
| in_a11 | input | 24 | Signed matrix entry, row 1 column 1 |
| in_a12 | input | 24 | Signed off-diagonal matrix entry |
| in_a22 | input | 24 | Signed matrix entry, row 2 column 2 |
| in_b1 | input | 24 | Signed first vector entry |
| in_b2 | input | 24 | Signed second vector entry |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_vx | output | 25 | Horizontal velocity, float |
| out_vy | output | 25 | Vertical velocity, float |
| out_invalid | output | 1 | Determinant was zero for this result |

## Verification
A fault in the way pointer or in a divider's cycle counter shows up in two ways. Results arrive at the wrong latency, or results belonging to a neighbouring solve are paired with the current input. Either is caught at the first result after the fault, 25 cycles after the affected input. Corrupted remainder or exponent state shows as a relative error far beyond the 16-bit fraction tolerance in the same result cycle. A wrong zero-divisor flag shows as a nonzero velocity, or as a missing `out_invalid`, on the singular directed cases.

// File: rtl/vsolve_pkg.sv
// Shared float format and single-cycle float arithmetic for the velocity solver.
// Assumes truncating arithmetic, no denormals, and all-zero as the only zero.
package vsolve_pkg;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 16;
    localparam int FLT_W   = 1 + EXP_W + MAN_W;
    localparam int BIAS    = 127;
    localparam int EXP_TOP = (1 << EXP_W) - 1;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } flt_t;

    // Largest finite magnitude with the given sign, used when an exponent overflows.
    function automatic flt_t flt_sat(input logic s);
        flt_t r;
        r.sgn = s;
        r.exp = EXP_W'(EXP_TOP - 1);
        r.man = '1;
        return r;
    endfunction

    // Truncating float product; a zero operand or an exponent underflow gives zero.
    function automatic flt_t fmul(input flt_t a, input flt_t b);
        logic [2*MAN_W+1:0] p;
        logic [MAN_W-1:0]   m;
        int                 e;
        flt_t               r;
        if (a.exp == '0 || b.exp == '0) return '0;
        p = {1'b1, a.man} * {1'b1, b.man};
        e = int'(a.exp) + int'(b.exp) - BIAS;
        if (p[2*MAN_W+1]) begin
            m = p[2*MAN_W -: MAN_W];
            e = e + 1;
        end else begin
            m = p[2*MAN_W-1 -: MAN_W];
        end
        if (e <= 0) return '0;
        if (e >= EXP_TOP) return flt_sat(a.sgn ^ b.sgn);
        r.sgn = a.sgn ^ b.sgn;
        r.exp = EXP_W'(e);
        r.man = m;
        return r;
    endfunction

    // Truncating float sum with full renormalisation after cancellation.
    function automatic flt_t fadd(input flt_t a, input flt_t b);
        flt_t             big, sml, r;
        logic [MAN_W+1:0] mb, ms, s;
        logic [MAN_W-1:0] m;
        int               d, e, pos;
        if (b.exp == '0) return (a.exp == '0) ? flt_t'('0) : a;
        if (a.exp == '0) return b;
        if ({a.exp, a.man} >= {b.exp, b.man}) begin
            big = a; sml = b;
        end else begin
            big = b; sml = a;
        end
        d  = int'(big.exp) - int'(sml.exp);
        mb = {1'b0, 1'b1, big.man};
        ms = (d > MAN_W + 1) ? '0 : ({1'b0, 1'b1, sml.man} >> d);
        e  = int'(big.exp);
        if (big.sgn == sml.sgn) begin
            s = mb + ms;
            if (s[MAN_W+1]) begin
                m = s[MAN_W -: MAN_W];
                e = e + 1;
            end else begin
                m = s[MAN_W-1:0];
            end
        end else begin
            s = mb - ms;
            if (s == '0) return '0;
            pos = 0;
            for (int i = 0; i <= MAN_W; i++) if (s[i]) pos = i;
            s = s << (MAN_W - pos);
            m = s[MAN_W-1:0];
            e = e - (MAN_W - pos);
        end
        if (e <= 0) return '0;
        if (e >= EXP_TOP) return flt_sat(big.sgn);
        r.sgn = big.sgn;
        r.exp = EXP_W'(e);
        r.man = m;
        return r;
    endfunction

    // Difference a - b built on the sum by flipping the sign of b.
    function automatic flt_t fsub(input flt_t a, input flt_t b);
        flt_t nb;
        nb     = b;
        nb.sgn = ~b.sgn;
        return fadd(a, nb);
    endfunction
endpackage

// File: rtl/vsolve_cvt.sv
// Fixed-to-float converter: a signed integer becomes a truncated 25-bit float.
// Assumes IN_W is below the exponent range, so the exponent cannot overflow.
module vsolve_cvt
    import vsolve_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  logic signed [IN_W-1:0] fx,
    output flt_t                   fl
);
    logic [IN_W-1:0]       mag;
    logic [IN_W+MAN_W-1:0] wide;
    int                    pos;

    // Magnitude, leading-one search, and left alignment of the fraction.
    always_comb begin
        mag  = fx[IN_W-1] ? (~fx + 1'b1) : fx;
        pos  = 0;
        for (int i = 0; i < IN_W; i++) if (mag[i]) pos = i;
        wide = {mag, MAN_W'(0)} << (IN_W - 1 - pos);
        if (mag == '0) begin
            fl = '0;
        end else begin
            fl.sgn = fx[IN_W-1];
            fl.exp = EXP_W'(BIAS + pos);
            fl.man = wide[IN_W+MAN_W-2 -: MAN_W];
        end
    end
endmodule

// File: rtl/vsolve_mat.sv
// Cross-product and difference stages: six products, then det and both numerators.
// Two register stages; the valid flag travels alongside the data.
module vsolve_mat
    import vsolve_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_v,
    input  flt_t a11,
    input  flt_t a12,
    input  flt_t a22,
    input  flt_t b1,
    input  flt_t b2,
    output logic out_v,
    output flt_t det,
    output flt_t nx,
    output flt_t ny
);
    flt_t p_dd, p_oo, p_x1, p_x2, p_y1, p_y2;
    logic p_v;

    // Product stage: every cross product in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_v  <= 1'b0;
            p_dd <= '0; p_oo <= '0; p_x1 <= '0;
            p_x2 <= '0; p_y1 <= '0; p_y2 <= '0;
        end else begin
            p_v  <= in_v;
            p_dd <= fmul(a11, a22);
            p_oo <= fmul(a12, a12);
            p_x1 <= fmul(a22, b1);
            p_x2 <= fmul(a12, b2);
            p_y1 <= fmul(a11, b2);
            p_y2 <= fmul(a12, b1);
        end
    end

    // Difference stage: determinant and the two numerators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            det   <= '0; nx <= '0; ny <= '0;
        end else begin
            out_v <= p_v;
            det   <= fsub(p_dd, p_oo);
            nx    <= fsub(p_x1, p_x2);
            ny    <= fsub(p_y1, p_y2);
        end
    end
endmodule

// File: rtl/vsolve_div.sv
// Sequential restoring float divider with a fixed latency of DIV_CYCLES cycles.
// Produces one quotient bit per cycle, then idles until its fixed finish cycle.
// A start in the finish cycle is accepted, so a way can be reused back to back.
// A zero divisor gives a zero quotient with dz set.
module vsolve_div
    import vsolve_pkg::*;
#(
    parameter int DIV_CYCLES = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  flt_t num,
    input  flt_t den,
    output logic done,
    output flt_t quo,
    output logic dz
);
    localparam int QBITS = MAN_W + 2;
    localparam int CW    = $clog2(DIV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DIV_CYCLES - 1);

    logic                   busy, sgn, nz, dzr;
    logic [CW-1:0]          cnt;
    logic [QBITS-1:0]       rem, q;
    logic [MAN_W:0]         dv;
    logic signed [EXP_W+1:0] ediff;
    flt_t                   fin;
    int                     e;

    // Normalise the finished quotient and apply the zero and range rules.
    always_comb begin
        e = int'(ediff) + BIAS;
        fin.sgn = sgn;
        if (q[QBITS-1]) begin
            fin.man = q[QBITS-2 -: MAN_W];
        end else begin
            fin.man = q[QBITS-3 -: MAN_W];
            e = e - 1;
        end
        fin.exp = EXP_W'(e);
        if (nz || dzr || e <= 0) fin = '0;
        else if (e >= EXP_TOP) fin = flt_sat(sgn);
    end

    // Iteration, finish, and operand capture (capture wins over finish).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0; dz <= 1'b0; quo <= '0;
            cnt <= '0; rem <= '0; q <= '0; dv <= '0;
            sgn <= 1'b0; nz <= 1'b0; dzr <= 1'b0; ediff <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == LAST) begin
                    quo  <= fin;
                    dz   <= dzr;
                    done <= 1'b1;
                    busy <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (int'(cnt) < QBITS) begin
                        if (rem >= {1'b0, dv}) begin
                            rem <= (rem - {1'b0, dv}) << 1;
                            q   <= {q[QBITS-2:0], 1'b1};
                        end else begin
                            rem <= rem << 1;
                            q   <= {q[QBITS-2:0], 1'b0};
                        end
                    end
                end
            end
            if (start) begin
                busy  <= 1'b1;
                cnt   <= '0;
                rem   <= {1'b0, 1'b1, num.man};
                dv    <= {1'b1, den.man};
                q     <= '0;
                sgn   <= num.sgn ^ den.sgn;
                nz    <= (num.exp == '0);
                dzr   <= (den.exp == '0);
                ediff <= $signed({2'b00, num.exp}) - $signed({2'b00, den.exp});
            end
        end
    end
endmodule

// File: rtl/vel_solver2x2.sv
// Regularised 2x2 velocity solver: converts, forms det and numerators,
// then divides in WAYS round-robin divider ways and returns results in order.
// Assumes in_valid pulses are at least ceil(DIV_CYCLES/WAYS) cycles apart.
module vel_solver2x2
    import vsolve_pkg::*;
#(
    parameter int IN_W       = 24,
    parameter int WAYS       = 3,
    parameter int DIV_CYCLES = 21
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_a11,
    input  logic signed [IN_W-1:0] in_a12,
    input  logic signed [IN_W-1:0] in_a22,
    input  logic signed [IN_W-1:0] in_b1,
    input  logic signed [IN_W-1:0] in_b2,
    output logic                   out_valid,
    output logic [FLT_W-1:0]       out_vx,
    output logic [FLT_W-1:0]       out_vy,
    output logic                   out_invalid
);
    localparam int NUM_IN = 5;
    localparam int PW     = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic signed [IN_W-1:0] in_fx [NUM_IN];
    flt_t                   cv    [NUM_IN];
    flt_t                   c_q   [NUM_IN];
    logic                   c_v;
    logic                   s_v;
    flt_t                   s_det, s_nx, s_ny;
    logic [PW-1:0]          ptr;
    logic [WAYS-1:0]        way_start, way_fin, dx_done, dy_done, dx_dz, dy_dz;
    flt_t                   way_vx [WAYS];
    flt_t                   way_vy [WAYS];
    logic                   m_any, m_inv;
    flt_t                   m_vx, m_vy;

    assign in_fx[0] = in_a11;
    assign in_fx[1] = in_a12;
    assign in_fx[2] = in_a22;
    assign in_fx[3] = in_b1;
    assign in_fx[4] = in_b2;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_cvt
        vsolve_cvt #(.IN_W(IN_W)) u_cvt (.fx(in_fx[i]), .fl(cv[i]));
    end

    // Conversion stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_v <= 1'b0;
            for (int i = 0; i < NUM_IN; i++) c_q[i] <= '0;
        end else begin
            c_v <= in_valid;
            for (int i = 0; i < NUM_IN; i++) c_q[i] <= cv[i];
        end
    end

    vsolve_mat u_mat (
        .clk(clk), .rst_n(rst_n), .in_v(c_v),
        .a11(c_q[0]), .a12(c_q[1]), .a22(c_q[2]), .b1(c_q[3]), .b2(c_q[4]),
        .out_v(s_v), .det(s_det), .nx(s_nx), .ny(s_ny)
    );

    // Round-robin way pointer advances once per dispatched solve.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (s_v) ptr <= (ptr == PW'(WAYS - 1)) ? '0 : ptr + 1'b1;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_start[w] = s_v && (ptr == PW'(w));
        assign way_fin[w]   = dx_done[w] & dy_done[w];
        vsolve_div #(.DIV_CYCLES(DIV_CYCLES)) u_dx (
            .clk(clk), .rst_n(rst_n), .start(way_start[w]), .num(s_nx), .den(s_det),
            .done(dx_done[w]), .quo(way_vx[w]), .dz(dx_dz[w])
        );
        vsolve_div #(.DIV_CYCLES(DIV_CYCLES)) u_dy (
            .clk(clk), .rst_n(rst_n), .start(way_start[w]), .num(s_ny), .den(s_det),
            .done(dy_done[w]), .quo(way_vy[w]), .dz(dy_dz[w])
        );
    end

    // Gather the single finishing way into one result.
    always_comb begin
        m_any = 1'b0; m_inv = 1'b0; m_vx = '0; m_vy = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_fin[w]) begin
                m_any = 1'b1;
                m_inv = m_inv | dx_dz[w] | dy_dz[w];
                m_vx  = m_vx | way_vx[w];
                m_vy  = m_vy | way_vy[w];
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_invalid <= 1'b0; out_vx <= '0; out_vy <= '0;
        end else begin
            out_valid   <= m_any;
            out_invalid <= m_inv;
            out_vx      <= m_vx;
            out_vy      <= m_vy;
        end
    end
endmodule

// File: rtl/vsolve_chk.sv
// Protocol and result-shape checks for the velocity solver, bound to the top.
module vsolve_chk #(
    parameter int WAYS       = 3,
    parameter int DIV_CYCLES = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic            out_invalid,
    input logic [24:0]     out_vx,
    input logic [24:0]     out_vy,
    input logic [WAYS-1:0] way_fin
);
    localparam int GAP = (DIV_CYCLES + WAYS - 1) / WAYS;

    logic [7:0] gap;
    logic [7:0] pending;

    // Cycles since the last accepted solve, saturating at the minimum spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) gap <= 8'(GAP);
        else if (in_valid) gap <= 8'd1;
        else if (int'(gap) < GAP) gap <= gap + 8'd1;
    end

    // Solves accepted but not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else pending <= pending + {7'd0, in_valid} - {7'd0, out_valid};
    end

    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> int'(gap) >= GAP);
    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    p_no_orphan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pending != 8'd0);
    p_one_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_fin));
    p_zero_on_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_vx == '0 && out_vy == '0));
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (out_valid || (!out_invalid && out_vx == '0 && out_vy == '0)));
endmodule

bind vel_solver2x2 vsolve_chk #(.WAYS(WAYS), .DIV_CYCLES(DIV_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_invalid(out_invalid), .out_vx(out_vx), .out_vy(out_vy), .way_fin(way_fin)
);

// File: tb/sim_vel_solver2x2.sv
// Bench: directed corners plus seeded random solves, checked against a real-valued model.
module sim_vel_solver2x2;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 24;
    localparam int WAYS       = 3;
    localparam int DIV_CYCLES = 21;
    localparam int GAP        = (DIV_CYCLES + WAYS - 1) / WAYS;
    localparam int LAT        = 4 + DIV_CYCLES;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int          a11, a12, a22, b1, b2;
        int          edge_no;
        bit          exact;
        logic [24:0] rx, ry;
    } job_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_a11 = '0, in_a12 = '0, in_a22 = '0, in_b1 = '0, in_b2 = '0;
    logic out_valid, out_invalid;
    logic [24:0] out_vx, out_vy;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    job_t jq[$];
    job_t cur;

    vel_solver2x2 #(.IN_W(IN_W), .WAYS(WAYS), .DIV_CYCLES(DIV_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a11(in_a11), .in_a12(in_a12), .in_a22(in_a22), .in_b1(in_b1), .in_b2(in_b2),
        .out_valid(out_valid), .out_vx(out_vx), .out_vy(out_vy), .out_invalid(out_invalid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic real f2r(input logic [24:0] f);
        real m;
        int  e;
        if (f[23:16] == 8'd0) return 0.0;
        m = 1.0 + real'(f[15:0]) / 65536.0;
        e = int'(f[23:16]) - 127;
        for (int i = 0; i < e; i++) m = m * 2.0;
        for (int i = 0; i < -e; i++) m = m / 2.0;
        return f[24] ? -m : m;
    endfunction

    function automatic real rabs(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    task automatic fail_line(input string req, input string what, input real act, input real exp);
        n_bad++;
        $display("FAIL %s %s: actual %g expected %g", req, what, act, exp);
    endtask

    // Present one solve, then hold off for the requested spacing.
    task automatic send(input int a11, input int a12, input int a22, input int b1, input int b2,
                        input int gap, input bit exact, input logic [24:0] rx, input logic [24:0] ry);
        job_t j;
        @(negedge clk);
        in_a11 = IN_W'(a11); in_a12 = IN_W'(a12); in_a22 = IN_W'(a22);
        in_b1 = IN_W'(b1); in_b2 = IN_W'(b2);
        in_valid = 1'b1;
        j.a11 = a11; j.a12 = a12; j.a22 = a22; j.b1 = b1; j.b2 = b2;
        j.edge_no = cyc + 1; j.exact = exact; j.rx = rx; j.ry = ry;
        jq.push_back(j);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    // Result monitor: latency, order and value checks.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (jq.size() == 0) begin
                n_cmp++;
                fail_line("R7", "result with no pending input", 1.0, 0.0);
            end else begin
                real det, ex, ey, tx, ty, scale;
                cur = jq.pop_front();
                n_cmp++;
                if (cyc - cur.edge_no != LAT)
                    fail_line("R5", "latency", real'(cyc - cur.edge_no), real'(LAT));
                det = real'(cur.a11) * real'(cur.a22) - real'(cur.a12) * real'(cur.a12);
                n_cmp++;
                if (cur.exact) begin
                    // R1 / R9: exact encodings, valid determinant
                    if (out_vx !== cur.rx || out_vy !== cur.ry || out_invalid !== 1'b0) begin
                        n_bad++;
                        $display("FAIL R1/R9 exact encoding: actual vx=%h vy=%h inv=%b expected vx=%h vy=%h inv=0",
                                 out_vx, out_vy, out_invalid, cur.rx, cur.ry);
                    end
                end else if (det == 0.0) begin
                    // R4: singular matrix
                    if (out_invalid !== 1'b1 || out_vx !== 25'd0 || out_vy !== 25'd0) begin
                        n_bad++;
                        $display("FAIL R4 singular: actual vx=%h vy=%h inv=%b expected 0 0 1",
                                 out_vx, out_vy, out_invalid);
                    end
                end else begin
                    // R2 / R3: value within truncation tolerance; R4: flag low
                    ex = (real'(cur.a22) * real'(cur.b1) - real'(cur.a12) * real'(cur.b2)) / det;
                    ey = (real'(cur.a11) * real'(cur.b2) - real'(cur.a12) * real'(cur.b1)) / det;
                    scale = (rabs(real'(cur.a11) * real'(cur.a22)) + real'(cur.a12) * real'(cur.a12)) / rabs(det);
                    tx = (rabs(real'(cur.a22) * real'(cur.b1)) + rabs(real'(cur.a12) * real'(cur.b2))) / rabs(det);
                    ty = (rabs(real'(cur.a11) * real'(cur.b2)) + rabs(real'(cur.a12) * real'(cur.b1))) / rabs(det);
                    tx = (tx + rabs(ex) * scale) / 2048.0 + 1.0e-30;
                    ty = (ty + rabs(ey) * scale) / 2048.0 + 1.0e-30;
                    if (out_invalid !== 1'b0) fail_line("R4", "flag on nonsingular", 1.0, 0.0);
                    if (rabs(f2r(out_vx) - ex) > tx) fail_line("R3", "vx", f2r(out_vx), ex);
                    n_cmp++;
                    if (rabs(f2r(out_vy) - ey) > ty) fail_line("R3", "vy", f2r(out_vy), ey);
                end
            end
        end
    end

    task automatic check_idle(input string why);
        n_cmp++;
        if (out_valid !== 1'b0 || out_vx !== 25'd0 || out_vy !== 25'd0 || out_invalid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 %s: actual valid=%b vx=%h vy=%h inv=%b expected all zero",
                     why, out_valid, out_vx, out_vy, out_invalid);
        end
    endtask

    initial begin
        int s;
        s = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        check_idle("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        // R1: 8/4 = 2.0 and -12/4 = -3.0 exactly
        send(2, 0, 2, 4, -6, GAP, 1'b1, 25'h0800000, 25'h1808000);
        // R1: unit solve gives 1.0 and -1.0
        send(1, 0, 1, 1, -1, GAP, 1'b1, 25'h07F0000, 25'h17F0000);
        // R9: zero right-hand side gives exact zeros
        send(5, 1, 3, 0, 0, GAP, 1'b1, 25'd0, 25'd0);
        // R4: singular 4*9 - 6*6 and the all-zero matrix
        send(4, 6, 9, 100, -50, GAP, 1'b0, '0, '0);
        send(0, 0, 0, 7, 7, GAP, 1'b0, '0, '0);
        // R2 / R3: full-scale operands including the most negative code
        send(8388607, -4194304, 8388607, -8388608, 8388607, GAP, 1'b0, '0, '0);
        // R3: negative determinant
        send(1000, 300, -500, 7, -9, GAP, 1'b0, '0, '0);

        // R6 / R7: random solves, many at the minimum spacing
        for (int k = 0; k < 40; k++) begin
            int a11, a22, a12, m, b1, b2, g;
            a11 = 1 + int'($urandom % 1048576);
            a22 = 1 + int'($urandom % 1048576);
            m   = ((a11 < a22) ? a11 : a22) / 2;
            a12 = int'($urandom % (2 * m + 1)) - m;
            b1  = int'($urandom % 2097152) - 1048576;
            b2  = int'($urandom % 2097152) - 1048576;
            g   = (k < 20) ? GAP : GAP + int'($urandom % 4);
            if ($urandom % 2 == 0) begin
                a11 = -a11; a22 = -a22;
            end
            send(a11, a12, a22, b1, b2, g, 1'b0, '0, '0);
        end

        repeat (LAT + 10) @(negedge clk);
        n_cmp++;
        if (jq.size() != 0) begin
            n_bad++;
            $display("FAIL R7 missing results: actual %0d pending expected 0", jq.size());
        end
        check_idle("after drain");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule